// File: doc/BRIEF.md
# Receive Frame Statistics Counter Bank

This block sits behind an Ethernet receive MAC and keeps per-frame statistics. At the end of each frame the MAC gives one strobe cycle that carries the frame length, the first two destination-address bytes and a CRC-error flag. From these the block classifies the frame and updates a set of clear-on-read counters: accepted frames, CRC-failed frames, broadcast, multicast, over-length frames, a six-bin length histogram and a wide accepted-octet total.

Software reads the counters through a small read port. A read clears the counter it returns, so the driver adds each value to its own running total. The octet total is wider than the read port and is read in two halves, low half first. The low-half read takes a snapshot. The high-half read returns the matching upper half and removes only the snapshotted amount, so bytes that arrive between the two reads stay in the counter.

Top module: `rx_stat_bank`

## Requirements
- R1: A frame whose CRC-error flag is 0 increments the accepted-frame counter (address 0) and adds its length to the octet total.
- R2: A frame whose CRC-error flag is 1 increments the CRC counter (address 1). It does not touch the accepted-frame counter, the octet total, the broadcast or multicast counters, or any histogram bin.
- R3: An accepted frame with destination bytes 0 and 1 both equal to 0xFF increments the broadcast counter (address 2) and never the multicast counter.
- R4: An accepted frame that is not broadcast and has bit 0 of destination byte 0 set increments the multicast counter (address 3).
- R5: Any frame, good or failed, whose length exceeds the parameter MAX_LEN (default 1518) increments the over-length counter (address 4).
- R6: An accepted frame increments exactly one histogram bin at addresses 5 to 10, selected by its length: 64, 65-127, 128-255, 256-511, 512-1023 and 1024-1522 bytes. Lengths below 64 or above 1522 select no bin.
- R7: When rd_en is high, rd_data shows the addressed value on the next cycle and the counter is cleared. If an increment falls on the same cycle as the read, the counter restarts at 1.
- R8: Each frame counter saturates at all-ones of its CNT_W width and does not wrap.
- R9: A read of address 11 returns the low half of the octet total and snapshots the whole total. A read of address 12 returns the upper half of that snapshot and subtracts the snapshot from the total, so octets added after the low-half read are kept. Carries from the low half into the high half are included.
- R10: After reset every counter reads 0. Addresses above 12 read as 0. Values narrower than 32 bits are zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_end | input | 1 | One-cycle end-of-frame strobe |
| frm_len | input | LEN_W | Frame length in bytes |
| frm_da0 | input | 8 | First destination-address byte |
| frm_da1 | input | 8 | Second destination-address byte |
| frm_crc_err | input | 1 | Frame failed its CRC check |
| rd_en | input | 1 | Read strobe; clears the addressed counter |
| rd_addr | input | 5 | Counter address |
| rd_data | output | 32 | Registered read data |

## Verification
A frame strobe updates the counters at the same rising edge, so the effect can be seen by a read issued on any later cycle. Read data is registered and is due one edge after the cycle that carries rd_en. The bench therefore drives every input at a falling edge and samples rd_data at the next falling edge. For the case where a read and an increment meet, the bench puts both on the same cycle. It expects the pre-increment value from that read and a value of 1 from the read that follows.

// File: rtl/rx_stat_pkg.sv
// Shared constants for the receive statistics bank: counter indices,
// read addresses and histogram bin bounds. Assumes six length bins.
package rx_stat_pkg;
    localparam int NUM_BINS   = 6;
    localparam int IDX_GOOD   = 0;
    localparam int IDX_CRC    = 1;
    localparam int IDX_BCAST  = 2;
    localparam int IDX_MCAST  = 3;
    localparam int IDX_OVER   = 4;
    localparam int IDX_BIN0   = 5;
    localparam int NUM_CNT    = IDX_BIN0 + NUM_BINS;
    localparam int ADDR_W     = 5;
    localparam int ADDR_OCT_LO = NUM_CNT;
    localparam int ADDR_OCT_HI = NUM_CNT + 1;

    // Lower bound (inclusive) of histogram bin b
    function automatic logic [31:0] bin_lo(input int b);
        case (b)
            0: bin_lo = 32'd64;
            1: bin_lo = 32'd65;
            2: bin_lo = 32'd128;
            3: bin_lo = 32'd256;
            4: bin_lo = 32'd512;
            default: bin_lo = 32'd1024;
        endcase
    endfunction

    // Upper bound (inclusive) of histogram bin b
    function automatic logic [31:0] bin_hi(input int b);
        case (b)
            0: bin_hi = 32'd64;
            1: bin_hi = 32'd127;
            2: bin_hi = 32'd255;
            3: bin_hi = 32'd511;
            4: bin_hi = 32'd1023;
            default: bin_hi = 32'd1522;
        endcase
    endfunction
endpackage

// File: rtl/rx_frame_classify.sv
// Turns one end-of-frame strobe into a vector of counter increments.
// Purely combinational; assumes frm_end is high for one cycle per frame.
module rx_frame_classify
    import rx_stat_pkg::*;
#(
    parameter int          LEN_W   = 14,
    parameter int unsigned MAX_LEN = 1518
) (
    input  logic             frm_end,
    input  logic [LEN_W-1:0] frm_len,
    input  logic [7:0]       frm_da0,
    input  logic [7:0]       frm_da1,
    input  logic             frm_crc_err,
    output logic [NUM_CNT-1:0] inc_vec
);
    logic accepted;
    logic is_bcast;
    logic is_mcast;
    logic [31:0] len32;
    logic [NUM_BINS-1:0] bin_hit;

    // Address class: broadcast is tested first since it also has the group bit
    always_comb begin
        len32    = 32'(frm_len);
        accepted = frm_end && !frm_crc_err;
        is_bcast = (frm_da0 == 8'hFF) && (frm_da1 == 8'hFF);
        is_mcast = !is_bcast && frm_da0[0];
    end

    // One range compare per histogram bin
    for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
        assign bin_hit[b] = accepted && (len32 >= bin_lo(b)) && (len32 <= bin_hi(b));
    end

    // Assemble the increment vector
    always_comb begin
        inc_vec                         = '0;
        inc_vec[IDX_GOOD]               = accepted;
        inc_vec[IDX_CRC]                = frm_end && frm_crc_err;
        inc_vec[IDX_BCAST]              = accepted && is_bcast;
        inc_vec[IDX_MCAST]              = accepted && is_mcast;
        inc_vec[IDX_OVER]               = frm_end && (len32 > MAX_LEN);
        inc_vec[IDX_BIN0 +: NUM_BINS]   = bin_hit;
    end

    // Classification consistency checks
    always_comb begin
        if (frm_end) begin
            a_r6_single_bin: assert ($onehot0(bin_hit));
            a_r3_bcast_excl: assert (!(inc_vec[IDX_BCAST] && inc_vec[IDX_MCAST]));
            a_r2_crc_not_good: assert (!(inc_vec[IDX_CRC] && inc_vec[IDX_GOOD]));
        end
    end
endmodule

// File: rtl/rx_sat_counter.sv
// Saturating clear-on-read event counter. A clear that meets an
// increment restarts the count at one. Assumes at most one event per cycle.
module rx_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = '1;

    // Count, clear on read, hold at all-ones
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= W'(inc);
        else if (inc && cnt != TOP)
            cnt <= cnt + 1'b1;
    end

    a_r8_hold_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == TOP && !clr) |=> cnt == TOP);
    a_r7_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !inc) |=> cnt == '0);
    a_r7_clear_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && inc) |=> cnt == W'(1));
endmodule

// File: rtl/rx_octet_counter.sv
// Wide octet accumulator read as two halves. A low-half read snapshots the
// total; a high-half read returns the snapshot's upper half and subtracts
// the snapshot. Assumes the two reads are never issued on the same cycle.
module rx_octet_counter #(
    parameter int OCT_W = 64,
    parameter int LEN_W = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               add_en,
    input  logic [LEN_W-1:0]   add_len,
    input  logic               rd_lo,
    input  logic               rd_hi,
    output logic [OCT_W/2-1:0] lo_word,
    output logic [OCT_W/2-1:0] hi_word
);
    localparam int HALF = OCT_W / 2;

    logic [OCT_W-1:0] acc;
    logic [OCT_W-1:0] snap;
    logic [OCT_W-1:0] addend;

    // Bytes added this cycle
    always_comb addend = add_en ? OCT_W'(add_len) : '0;

    // Accumulate; drop the snapshotted amount on a high-half read
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (rd_hi)
            acc <= acc - snap + addend;
        else
            acc <= acc + addend;
    end

    // Snapshot on low-half read, release on high-half read
    always_ff @(posedge clk) begin
        if (!rst_n)
            snap <= '0;
        else if (rd_lo)
            snap <= acc;
        else if (rd_hi)
            snap <= '0;
    end

    assign lo_word = acc[HALF-1:0];
    assign hi_word = snap[OCT_W-1:HALF];

    a_r9_snap_release: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi |=> snap == '0);
    a_r9_idle_grow: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_hi && !add_en) |=> acc == $past(acc));
    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_lo && rd_hi));
endmodule

// File: rtl/rx_stat_bank.sv
// Receive statistics bank: classifies each frame, keeps the frame counters
// and the octet total, and serves registered clear-on-read reads.
// Assumes CNT_W and OCT_W/2 are at most 32.
module rx_stat_bank
    import rx_stat_pkg::*;
#(
    parameter int          CNT_W   = 32,
    parameter int          OCT_W   = 64,
    parameter int          LEN_W   = 14,
    parameter int unsigned MAX_LEN = 1518
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_end,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic [7:0]        frm_da0,
    input  logic [7:0]        frm_da1,
    input  logic              frm_crc_err,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data
);
    localparam int HALF = OCT_W / 2;

    logic [NUM_CNT-1:0] inc_vec;
    logic [NUM_CNT-1:0] clr_vec;
    logic [CNT_W-1:0]   cnt_q [NUM_CNT];
    logic [HALF-1:0]    oct_lo;
    logic [HALF-1:0]    oct_hi;
    logic               rd_lo;
    logic               rd_hi;
    logic [31:0]        rd_next;

    rx_frame_classify #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_classify (
        .frm_end     (frm_end),
        .frm_len     (frm_len),
        .frm_da0     (frm_da0),
        .frm_da1     (frm_da1),
        .frm_crc_err (frm_crc_err),
        .inc_vec     (inc_vec)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        assign clr_vec[i] = rd_en && (rd_addr == ADDR_W'(i));
        rx_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc_vec[i]),
            .clr   (clr_vec[i]),
            .cnt   (cnt_q[i])
        );
    end

    assign rd_lo = rd_en && (rd_addr == ADDR_W'(ADDR_OCT_LO));
    assign rd_hi = rd_en && (rd_addr == ADDR_W'(ADDR_OCT_HI));

    rx_octet_counter #(.OCT_W(OCT_W), .LEN_W(LEN_W)) u_octets (
        .clk     (clk),
        .rst_n   (rst_n),
        .add_en  (inc_vec[IDX_GOOD]),
        .add_len (frm_len),
        .rd_lo   (rd_lo),
        .rd_hi   (rd_hi),
        .lo_word (oct_lo),
        .hi_word (oct_hi)
    );

    // Select the addressed value, zero-extended
    always_comb begin
        rd_next = '0;
        for (int i = 0; i < NUM_CNT; i++)
            if (rd_addr == ADDR_W'(i)) rd_next = 32'(cnt_q[i]);
        if (rd_lo) rd_next = 32'(oct_lo);
        if (rd_hi) rd_next = 32'(oct_hi);
    end

    // Register the read result
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= rd_next;
    end

    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr > ADDR_W'(ADDR_OCT_HI)) |=> rd_data == '0);
    a_r10_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: tb/rx_stat_bank_bench.sv
`timescale 1ns/1ps
module rx_stat_bank_bench;
    localparam int CNT_W = 4;
    localparam int OCT_W = 16;
    localparam int HALF  = OCT_W / 2;

    typedef struct packed {
        logic [15:0] len;
        logic [7:0]  da0;
        logic [7:0]  da1;
        logic        crc;
        logic [10:0] mask;  // counters 0..10 expected to read 1
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{16'd64,   8'h01, 8'h00, 1'b0, 11'h029},
        '{16'd127,  8'hFF, 8'hFF, 1'b0, 11'h045},
        '{16'd128,  8'h00, 8'h00, 1'b0, 11'h081},
        '{16'd300,  8'hFF, 8'h00, 1'b0, 11'h109},
        '{16'd1000, 8'hFF, 8'hFF, 1'b1, 11'h002},
        '{16'd1522, 8'h00, 8'h00, 1'b0, 11'h411},
        '{16'd63,   8'h00, 8'h00, 1'b0, 11'h001},
        '{16'd1600, 8'h00, 8'h00, 1'b0, 11'h011},
        '{16'd2000, 8'h01, 8'h00, 1'b1, 11'h012},
        '{16'd512,  8'h03, 8'h55, 1'b0, 11'h209}
    };

    logic        clk = 0;
    logic        rst_n = 0;
    logic        frm_end = 0;
    logic [13:0] frm_len = '0;
    logic [7:0]  frm_da0 = '0;
    logic [7:0]  frm_da1 = '0;
    logic        frm_crc_err = 0;
    logic        rd_en = 0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    rx_stat_bank #(.CNT_W(CNT_W), .OCT_W(OCT_W)) u_rx_stat_bank (
        .clk(clk), .rst_n(rst_n), .frm_end(frm_end), .frm_len(frm_len),
        .frm_da0(frm_da0), .frm_da1(frm_da1), .frm_crc_err(frm_crc_err),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] len, input logic [7:0] d0,
                        input logic [7:0] d1, input logic crc);
        @(negedge clk);
        frm_end = 1; frm_len = len[13:0]; frm_da0 = d0; frm_da1 = d1; frm_crc_err = crc;
        @(negedge clk);
        frm_end = 0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1; rd_addr = 5'(a);
        @(negedge clk);
        rd_en = 0;
        v = rd_data;
    endtask

    function automatic string req_of(input int i);
        case (i)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [15:0] olen;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R10: reset state
        rd(0, v);  chk("R10 reset good", v, 0);
        rd(11, v); chk("R10 reset octet lo", v, 0);

        // Table walk: one frame, then every counter and the octet halves
        for (int k = 0; k < NV; k++) begin
            send(VECS[k].len, VECS[k].da0, VECS[k].da1, VECS[k].crc);
            for (int i = 0; i < 11; i++) begin
                rd(i, v);
                chk(req_of(i), v, {31'b0, VECS[k].mask[i]});
            end
            olen = VECS[k].crc ? 16'd0 : VECS[k].len;
            rd(11, v); chk("R1 octet lo", v, 32'(olen[HALF-1:0]));
            rd(12, v); chk("R9 octet hi", v, 32'(olen[OCT_W-1:HALF]));
        end

        // R8: saturation at all-ones of a 4-bit counter; R9 carry into high half
        for (int i = 0; i < 20; i++) send(16'd64, 8'h00, 8'h00, 1'b0);
        rd(0, v);  chk("R8 saturate good", v, 15);
        rd(5, v);  chk("R8 saturate bin", v, 15);
        rd(11, v); chk("R9 carry lo", v, 32'(1280 % 256));
        rd(12, v); chk("R9 carry hi", v, 32'(1280 / 256));

        // R9: bytes arriving between the two half reads are kept
        send(16'd100, 8'h00, 8'h00, 1'b0);
        rd(11, v); chk("R9 snap lo", v, 100);
        send(16'd50, 8'h00, 8'h00, 1'b0);
        rd(12, v); chk("R9 snap hi", v, 0);
        rd(11, v); chk("R9 kept lo", v, 50);
        rd(12, v); chk("R9 kept hi", v, 0);
        rd(0, v);  chk("R7 drain good", v, 2);

        // R7: read and increment on the same cycle
        send(16'd70, 8'h00, 8'h00, 1'b0);
        send(16'd70, 8'h00, 8'h00, 1'b0);
        @(negedge clk);
        frm_end = 1; frm_len = 14'd70; frm_crc_err = 0; rd_en = 1; rd_addr = 5'd0;
        @(negedge clk);
        frm_end = 0; rd_en = 0;
        chk("R7 read before inc", rd_data, 2);
        rd(0, v); chk("R7 restart at one", v, 1);
        rd(0, v); chk("R7 cleared", v, 0);

        // R10: unmapped address
        rd(20, v); chk("R10 unmapped", v, 0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule